// File: doc/BRIEF.md
# Write-Back Data Cache with Cache-Disable Mode

This block is a direct-mapped, write-back data cache placed between a CPU load/store port and a single-beat main-memory port. It also answers coherence probes from the system. Each line stores one data word, a tag and a three-way state: Invalid, Clean or Dirty. Dirty covers both a locally modified copy and an owned copy. A control register holds a cache-disable bit. When that bit is clear, the cache allocates on read and write misses and writes dirty victims back before it reuses a line.

When the disable bit is set, nothing new is allocated. A CPU access that misses goes to memory uncached and leaves the cache contents as they were. A CPU access that hits a line is not served from that line. A dirty line is first written back and becomes Clean, the line is then invalidated, and then the access is done uncached in memory.

Probes are serviced in both modes. A probe that hits a Dirty line forces a writeback. A probe that hits invalidates the line only when it is issued for an exclusive read or for a write.

Top module: `wb_cache`

## Requirements
- R1: After reset every line is Invalid, the control register reads 0, and `mem_valid`, `cpu_done` and `prb_done` are low.
- R2: The control register stores every bit written through `ctl_we`/`ctl_wdata` and returns it on `ctl_q`. Bit 30 is the cache disable (1 = disabled). Bit 29 is stored but has no effect on how the cache operates.
- R3: Enabled read miss: a Dirty victim is written back to its own address first. Then one memory read fills the line as Clean and returns the data. A later read of the same address hits with no memory transaction.
- R4: Enabled write hit: the line is updated and marked Dirty with no memory transaction. Enabled write miss: the line is allocated Dirty after any victim writeback, with no memory read.
- R5: Disabled miss: exactly one uncached memory access is made at the request address, and no line is allocated or changed.
- R6: Disabled hit on a Dirty line: the line is written back, invalidated, and then the request is done as an uncached memory access. After a writeback the line holds state Clean.
- R7: Disabled hit on a Clean line: no memory write of the line. The line is invalidated and the request is done uncached.
- R8: Probe kinds are encoded on `prb_kind` as 0 = shared read, 1 = exclusive read, 2 = write, 3 = other read. `prb_hit` reports a hit. A hit on a Dirty line writes it back. Only kinds 1 and 2 invalidate. After any other probe hit the line stays valid and Clean. This holds in both modes.
- R9: A probe and a CPU request that arrive in the same cycle are handled probe first. A probe that arrives while a CPU request is in progress waits until that request completes.
- R10: The disable bit is sampled when a CPU request is accepted. Changing it during the request affects only later requests.
- R11: The memory port has one transaction in flight. `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` stay stable until `mem_ready`. The transfer completes in the cycle where both are high, and read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control register write value |
| ctl_q | output | 32 | Control register contents (bit 30 = disable) |
| cpu_req | input | 1 | CPU request, held until `cpu_done` |
| cpu_we | input | 1 | CPU request is a store |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 32 | CPU store data |
| cpu_done | output | 1 | One-cycle completion pulse for the CPU request |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| prb_req | input | 1 | Probe request, held until `prb_done` |
| prb_addr | input | 16 | Probe byte address |
| prb_kind | input | 2 | Probe kind (0 shared, 1 exclusive, 2 write, 3 other) |
| prb_done | output | 1 | One-cycle completion pulse for the probe |
| prb_hit | output | 1 | Probe found a valid line, valid with `prb_done` |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts or completes the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ready` |

## Verification
The main function is tried with read and write sequences that alias on one index under two tags. These tell a clean victim from a dirty one by the number of memory writes observed. The same addresses are then used with the disable bit set, so that Dirty hits, Clean hits and misses each give a distinct count of memory reads and writes. A read after re-enabling shows whether the line was invalidated or kept. Probes of every kind are aimed at Dirty, Clean and absent lines, and a follow-up CPU read separates kept lines from invalidated ones. Directed sequences with a slow memory collide probes with CPU requests, toggle the disable bit mid-request, and repeat a reset.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   typedef enum logic [1:0] {
      LN_INV   = 2'd0,
      LN_CLEAN = 2'd1,
      LN_DIRTY = 2'd2
   } line_st_e;

   typedef enum logic [2:0] {
      S_IDLE = 3'd0,
      S_LOOK = 3'd1,
      S_WB   = 3'd2,
      S_KILL = 3'd3,
      S_FILL = 3'd4,
      S_UNC  = 3'd5,
      S_DONE = 3'd6
   } fsm_e;

   // exclusive-read (1) and write (2) probes remove the line
   function automatic logic probe_kills(input logic [1:0] kind);
      return (kind == 2'd1) || (kind == 2'd2);
   endfunction

endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store
   import wbc_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int TAG_W = 10,
   parameter int DW    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output line_st_e         rd_state,
   output logic [TAG_W-1:0] rd_tag,
   output logic [DW-1:0]    rd_data,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  line_st_e         wr_state,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [DW-1:0]    wr_data
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0][1:0]       st_flat;
   logic [LINES-1:0][TAG_W-1:0] tag_flat;
   logic [LINES-1:0][DW-1:0]    dat_flat;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [1:0]       st_q;
      logic [TAG_W-1:0] tag_q;
      logic [DW-1:0]    dat_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q  <= LN_INV;
            tag_q <= '0;
            dat_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            st_q  <= wr_state;
            tag_q <= wr_tag;
            dat_q <= wr_data;
         end
      end
      assign st_flat[g]  = st_q;
      assign tag_flat[g] = tag_q;
      assign dat_flat[g] = dat_q;
   end

   assign rd_state = line_st_e'(st_flat[rd_idx]);
   assign rd_tag   = tag_flat[rd_idx];
   assign rd_data  = dat_flat[rd_idx];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
   import wbc_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int IDX_W = 4,
   parameter int OFF_W = 2,
   localparam int TAG_W = AW - IDX_W - OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cache_dis,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             cpu_done,
   output logic [DW-1:0]    cpu_rdata,
   input  logic             prb_req,
   input  logic [AW-1:0]    prb_addr,
   input  logic [1:0]       prb_kind,
   output logic             prb_done,
   output logic             prb_hit,
   output logic             mem_valid,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ready,
   input  logic [DW-1:0]    mem_rdata,
   output logic [IDX_W-1:0] st_rd_idx,
   input  line_st_e         st_rd_state,
   input  logic [TAG_W-1:0] st_rd_tag,
   input  logic [DW-1:0]    st_rd_data,
   output logic             st_wr_en,
   output logic [IDX_W-1:0] st_wr_idx,
   output line_st_e         st_wr_state,
   output logic [TAG_W-1:0] st_wr_tag,
   output logic [DW-1:0]    st_wr_data
);
   fsm_e            state_q, nxt;
   logic            is_prb_q, we_q, dis_q, hit_q;
   logic [1:0]      kind_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q, rdata_q, rdata_nxt;
   logic            take_prb, take_cpu, ld_hit, ld_rdata;

   wire [IDX_W-1:0] idx_w     = addr_q[OFF_W +: IDX_W];
   wire [TAG_W-1:0] tag_w     = addr_q[AW-1 -: TAG_W];
   wire             hit       = (st_rd_state != LN_INV) && (st_rd_tag == tag_w);
   wire             dirty     = (st_rd_state == LN_DIRTY);
   wire             kill_kind = probe_kills(kind_q);

   assign st_rd_idx = idx_w;
   assign st_wr_idx = idx_w;

   always_comb begin
      nxt         = state_q;
      st_wr_en    = 1'b0;
      st_wr_state = st_rd_state;
      st_wr_tag   = st_rd_tag;
      st_wr_data  = st_rd_data;
      mem_valid   = 1'b0;
      mem_we      = 1'b0;
      mem_addr    = addr_q;
      mem_wdata   = wdata_q;
      take_prb    = 1'b0;
      take_cpu    = 1'b0;
      ld_hit      = 1'b0;
      ld_rdata    = 1'b0;
      rdata_nxt   = st_rd_data;
      case (state_q)
         S_IDLE: begin
            if (prb_req) begin
               take_prb = 1'b1;
               nxt      = S_LOOK;
            end else if (cpu_req) begin
               take_cpu = 1'b1;
               nxt      = S_LOOK;
            end
         end
         S_LOOK: begin
            if (is_prb_q) begin
               ld_hit = 1'b1;
               if (hit && dirty)          nxt = S_WB;
               else if (hit && kill_kind) nxt = S_KILL;
               else                       nxt = S_DONE;
            end else if (dis_q) begin
               if (hit && dirty) nxt = S_WB;
               else if (hit)     nxt = S_KILL;
               else              nxt = S_UNC;
            end else if (hit) begin
               if (we_q) begin
                  st_wr_en    = 1'b1;
                  st_wr_state = LN_DIRTY;
                  st_wr_data  = wdata_q;
               end else begin
                  ld_rdata = 1'b1;
               end
               nxt = S_DONE;
            end else if (dirty) begin
               nxt = S_WB;
            end else if (we_q) begin
               st_wr_en    = 1'b1;
               st_wr_state = LN_DIRTY;
               st_wr_tag   = tag_w;
               st_wr_data  = wdata_q;
               nxt         = S_DONE;
            end else begin
               nxt = S_FILL;
            end
         end
         S_WB: begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {st_rd_tag, idx_w, {OFF_W{1'b0}}};
            mem_wdata = st_rd_data;
            if (mem_ready) begin
               st_wr_en    = 1'b1;
               st_wr_state = LN_CLEAN;
               if (is_prb_q ? kill_kind : dis_q) nxt = S_KILL;
               else if (is_prb_q)                nxt = S_DONE;
               else                              nxt = S_LOOK;
            end
         end
         S_KILL: begin
            st_wr_en    = 1'b1;
            st_wr_state = LN_INV;
            nxt         = is_prb_q ? S_DONE : S_UNC;
         end
         S_FILL: begin
            mem_valid = 1'b1;
            if (mem_ready) begin
               st_wr_en    = 1'b1;
               st_wr_state = LN_CLEAN;
               st_wr_tag   = tag_w;
               st_wr_data  = mem_rdata;
               ld_rdata    = 1'b1;
               rdata_nxt   = mem_rdata;
               nxt         = S_DONE;
            end
         end
         S_UNC: begin
            mem_valid = 1'b1;
            mem_we    = we_q;
            if (mem_ready) begin
               if (!we_q) begin
                  ld_rdata  = 1'b1;
                  rdata_nxt = mem_rdata;
               end
               nxt = S_DONE;
            end
         end
         S_DONE:  nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         is_prb_q <= 1'b0;
         we_q     <= 1'b0;
         dis_q    <= 1'b0;
         hit_q    <= 1'b0;
         kind_q   <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         rdata_q  <= '0;
      end else begin
         state_q <= nxt;
         if (take_prb) begin
            is_prb_q <= 1'b1;
            we_q     <= 1'b0;
            addr_q   <= prb_addr;
            kind_q   <= prb_kind;
            hit_q    <= 1'b0;
         end
         if (take_cpu) begin
            is_prb_q <= 1'b0;
            we_q     <= cpu_we;
            addr_q   <= cpu_addr;
            wdata_q  <= cpu_wdata;
            dis_q    <= cache_dis;
         end
         if (ld_hit)   hit_q   <= hit;
         if (ld_rdata) rdata_q <= rdata_nxt;
      end
   end

   assign cpu_done  = (state_q == S_DONE) && !is_prb_q;
   assign prb_done  = (state_q == S_DONE) && is_prb_q;
   assign cpu_rdata = rdata_q;
   assign prb_hit   = hit_q;

   // R11: request held steady until accepted
   assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R6: a completed writeback leaves the line Clean
   assert_wb_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WB && mem_ready) |=> (st_rd_state == LN_CLEAN));

   // R5: an uncached access leaves the indexed line untouched
   assert_unc_no_alloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_UNC && mem_ready) |=> $stable(st_rd_state) && $stable(st_rd_tag));

   // R8: line state at probe completion follows the probe kind
   assert_probe_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (prb_done && prb_hit) |-> (st_rd_state == (kill_kind ? LN_INV : LN_CLEAN)));

   // R10: the sampled disable bit is frozen for the whole request
   assert_dis_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != S_IDLE && state_q != S_DONE) |=> $stable(dis_q));

   // R9: a probe present at acceptance is taken first
   assert_probe_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && prb_req) |=> is_prb_q);

endmodule

// File: rtl/wb_cache.sv
module wb_cache
   import wbc_pkg::*;
#(
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter int IDX_W   = 4,
   parameter int CTL_W   = 32,
   parameter int DIS_BIT = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_q,
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [DW-1:0]    cpu_wdata,
   output logic             cpu_done,
   output logic [DW-1:0]    cpu_rdata,
   input  logic             prb_req,
   input  logic [AW-1:0]    prb_addr,
   input  logic [1:0]       prb_kind,
   output logic             prb_done,
   output logic             prb_hit,
   output logic             mem_valid,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ready,
   input  logic [DW-1:0]    mem_rdata
);
   localparam int OFF_W = $clog2(DW / 8);
   localparam int TAG_W = AW - IDX_W - OFF_W;

   if (TAG_W < 1) begin : g_bad_aw
      $error("wb_cache: AW too small for IDX_W and word offset");
   end
   if (DIS_BIT >= CTL_W) begin : g_bad_dis
      $error("wb_cache: DIS_BIT outside control register");
   end
   if (DW % 8 != 0) begin : g_bad_dw
      $error("wb_cache: DW must be whole bytes");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_we) ctl_q <= ctl_wdata;
   end

   logic [IDX_W-1:0] st_rd_idx, st_wr_idx;
   line_st_e         st_rd_state, st_wr_state;
   logic [TAG_W-1:0] st_rd_tag, st_wr_tag;
   logic [DW-1:0]    st_rd_data, st_wr_data;
   logic             st_wr_en;

   wbc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) store_i (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(st_rd_idx), .rd_state(st_rd_state), .rd_tag(st_rd_tag), .rd_data(st_rd_data),
      .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_state(st_wr_state),
      .wr_tag(st_wr_tag), .wr_data(st_wr_data)
   );

   wbc_ctrl #(.AW(AW), .DW(DW), .IDX_W(IDX_W), .OFF_W(OFF_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .cache_dis(ctl_q[DIS_BIT]),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .prb_req(prb_req), .prb_addr(prb_addr), .prb_kind(prb_kind),
      .prb_done(prb_done), .prb_hit(prb_hit),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .st_rd_idx(st_rd_idx), .st_rd_state(st_rd_state), .st_rd_tag(st_rd_tag),
      .st_rd_data(st_rd_data), .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx),
      .st_wr_state(st_wr_state), .st_wr_tag(st_wr_tag), .st_wr_data(st_wr_data)
   );

   // R1: no activity straight out of reset
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!mem_valid && !cpu_done && !prb_done && ctl_q == '0));

endmodule

// File: tb/wb_cache_tb_top.sv
`timescale 1ns/1ps
module wb_cache_tb_top;

   localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_PRB = 2'd2, OP_CTL = 2'd3;

   typedef struct packed {
      logic [1:0]  op;
      logic [3:0]  req;
      logic [15:0] addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [2:0]  nmem;
      logic [2:0]  nwr;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t VECS [NV] = '{
      '{OP_RD,  4'd3, 16'h0004, 32'h0,        32'h10000004, 3'd1, 3'd0}, // R3 cold miss
      '{OP_RD,  4'd3, 16'h0004, 32'h0,        32'h10000004, 3'd0, 3'd0}, // R3 hit
      '{OP_WR,  4'd4, 16'h0004, 32'hDEAD0001, 32'h0,        3'd0, 3'd0}, // R4 write hit
      '{OP_RD,  4'd4, 16'h0004, 32'h0,        32'hDEAD0001, 3'd0, 3'd0}, // R4
      '{OP_RD,  4'd3, 16'h0044, 32'h0,        32'h10000044, 3'd2, 3'd1}, // R3 dirty victim
      '{OP_RD,  4'd3, 16'h0004, 32'h0,        32'hDEAD0001, 3'd1, 3'd0}, // R3 clean victim
      '{OP_WR,  4'd4, 16'h0008, 32'h0000C0DE, 32'h0,        3'd0, 3'd0}, // R4 write miss
      '{OP_RD,  4'd4, 16'h0008, 32'h0,        32'h0000C0DE, 3'd0, 3'd0}, // R4
      '{OP_CTL, 4'd2, 16'h0,    32'h20000000, 32'h20000000, 3'd0, 3'd0}, // R2 bit 29
      '{OP_RD,  4'd2, 16'h0008, 32'h0,        32'h0000C0DE, 3'd0, 3'd0}, // R2 still caching
      '{OP_CTL, 4'd2, 16'h0,    32'h40000000, 32'h40000000, 3'd0, 3'd0}, // R2 disable
      '{OP_RD,  4'd5, 16'h0044, 32'h0,        32'h10000044, 3'd1, 3'd0}, // R5 disabled miss
      '{OP_CTL, 4'd2, 16'h0,    32'h0,        32'h0,        3'd0, 3'd0},
      '{OP_RD,  4'd5, 16'h0004, 32'h0,        32'hDEAD0001, 3'd0, 3'd0}, // R5 old line kept
      '{OP_CTL, 4'd2, 16'h0,    32'h40000000, 32'h40000000, 3'd0, 3'd0},
      '{OP_RD,  4'd6, 16'h0008, 32'h0,        32'h0000C0DE, 3'd2, 3'd1}, // R6 dirty hit
      '{OP_RD,  4'd6, 16'h0008, 32'h0,        32'h0000C0DE, 3'd1, 3'd0}, // R6 now invalid
      '{OP_WR,  4'd7, 16'h0004, 32'h5555AAAA, 32'h0,        3'd1, 3'd1}, // R7 clean hit write
      '{OP_CTL, 4'd2, 16'h0,    32'h0,        32'h0,        3'd0, 3'd0},
      '{OP_RD,  4'd7, 16'h0004, 32'h0,        32'h5555AAAA, 3'd1, 3'd0}, // R7 was invalidated
      '{OP_WR,  4'd4, 16'h0004, 32'h11112222, 32'h0,        3'd0, 3'd0},
      '{OP_PRB, 4'd8, 16'h0004, 32'h0,        32'h1,        3'd1, 3'd1}, // R8 shared dirty
      '{OP_RD,  4'd8, 16'h0004, 32'h0,        32'h11112222, 3'd0, 3'd0}, // R8 kept
      '{OP_PRB, 4'd8, 16'h0004, 32'h1,        32'h1,        3'd0, 3'd0}, // R8 excl clean
      '{OP_RD,  4'd8, 16'h0004, 32'h0,        32'h11112222, 3'd1, 3'd0}, // R8 removed
      '{OP_WR,  4'd4, 16'h0004, 32'h33334444, 32'h0,        3'd0, 3'd0},
      '{OP_PRB, 4'd8, 16'h0004, 32'h2,        32'h1,        3'd1, 3'd1}, // R8 write dirty
      '{OP_RD,  4'd8, 16'h0004, 32'h0,        32'h33334444, 3'd1, 3'd0}, // R8 removed
      '{OP_PRB, 4'd8, 16'h0080, 32'h1,        32'h0,        3'd0, 3'd0}, // R8 probe miss
      '{OP_CTL, 4'd2, 16'h0,    32'h40000000, 32'h40000000, 3'd0, 3'd0},
      '{OP_PRB, 4'd8, 16'h0004, 32'h3,        32'h1,        3'd0, 3'd0}, // R8 disabled clean
      '{OP_RD,  4'd7, 16'h0004, 32'h0,        32'h33334444, 3'd1, 3'd0}, // R7 read clean hit
      '{OP_CTL, 4'd2, 16'h0,    32'h0,        32'h0,        3'd0, 3'd0},
      '{OP_RD,  4'd7, 16'h0004, 32'h0,        32'h33334444, 3'd1, 3'd0}, // R7 was invalidated
      '{OP_WR,  4'd4, 16'h0004, 32'h00000077, 32'h0,        3'd0, 3'd0},
      '{OP_CTL, 4'd2, 16'h0,    32'h40000000, 32'h40000000, 3'd0, 3'd0},
      '{OP_PRB, 4'd8, 16'h0004, 32'h0,        32'h1,        3'd1, 3'd1}, // R8 disabled dirty
      '{OP_CTL, 4'd2, 16'h0,    32'h0,        32'h0,        3'd0, 3'd0},
      '{OP_RD,  4'd8, 16'h0004, 32'h0,        32'h00000077, 3'd0, 3'd0}  // R8 kept
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic [31:0] ctl_q;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        prb_req = 1'b0;
   logic [15:0] prb_addr = '0;
   logic [1:0]  prb_kind = '0;
   logic        prb_done, prb_hit;
   logic        mem_valid, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;

   int checks = 0, failures = 0;
   int mem_cnt = 0, wr_cnt = 0, hs_viol = 0, lat = 0, wait_cnt = 0, cyc = 0;
   logic        pend = 1'b0;
   logic [15:0] pend_addr = '0;
   logic [31:0] mem_arr [256];

   always #2 clk = ~clk;

   wb_cache dut_i (.*);

   // memory model: decides ready for the coming edge, away from it
   always @(negedge clk) begin
      if (pend && (!mem_valid || mem_addr != pend_addr)) hs_viol++;
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem_arr[i] = 32'h1000_0000 | (i << 2);
         mem_ready = 1'b0;
         wait_cnt  = 0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
         wait_cnt  = 0;
      end else if (mem_valid) begin
         if (wait_cnt >= lat) begin
            mem_ready = 1'b1;
            mem_cnt++;
            if (mem_we) begin
               wr_cnt++;
               mem_arr[mem_addr[9:2]] = mem_wdata;
            end else begin
               mem_rdata = mem_arr[mem_addr[9:2]];
            end
         end else begin
            wait_cnt++;
         end
      end
      pend      = mem_valid && !mem_ready && rst_n;
      pend_addr = mem_addr;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         failures++;
         $display("FAIL R11 watchdog actual=%0d expected=<150000", cyc);
         summary_and_end();
      end
   end

   task automatic do_cpu(input logic we, input logic [15:0] a, input logic [31:0] d,
                         output logic [31:0] rd);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
      for (int t = 0; t < 200; t++) begin
         @(negedge clk);
         if (cpu_done) break;
      end
      rd = cpu_rdata;
      cpu_req = 1'b0;
   endtask

   task automatic do_prb(input logic [15:0] a, input logic [1:0] k, output logic h);
      @(negedge clk);
      prb_req = 1'b1; prb_addr = a; prb_kind = k;
      for (int t = 0; t < 200; t++) begin
         @(negedge clk);
         if (prb_done) break;
      end
      h = prb_hit;
      prb_req = 1'b0;
   endtask

   task automatic do_ctl(input logic [31:0] v);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   // both requests raised at once; records the cycle each completes
   task automatic race(input logic [15:0] ca, input logic [15:0] pa, input int gap,
                       output int tc, output int tp);
      tc = -1; tp = -1;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ca;
      if (gap == 0) begin prb_req = 1'b1; prb_addr = pa; prb_kind = 2'd0; end
      for (int t = 1; t < 300; t++) begin
         @(negedge clk);
         if (t == gap) begin prb_req = 1'b1; prb_addr = pa; prb_kind = 2'd0; end
         if (cpu_done && tc < 0) begin tc = t; cpu_req = 1'b0; end
         if (prb_done && tp < 0) begin tp = t; prb_req = 1'b0; end
         if (tc >= 0 && tp >= 0) break;
      end
   endtask

   initial begin
      logic [31:0] rd;
      logic        h;
      int          m0, w0, tc, tp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ctl_q == 32'h0, "R1", "ctl_q after reset", ctl_q, 32'h0);
      check({mem_valid, cpu_done, prb_done} == 3'b000, "R1", "idle outputs",
            {29'h0, mem_valid, cpu_done, prb_done}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         m0 = mem_cnt; w0 = wr_cnt;
         case (VECS[v].op)
            OP_RD: begin
               do_cpu(1'b0, VECS[v].addr, 32'h0, rd);
               check(rd == VECS[v].exp, $sformatf("R%0d", VECS[v].req),
                     $sformatf("vec %0d rdata", v), rd, VECS[v].exp);
            end
            OP_WR: do_cpu(1'b1, VECS[v].addr, VECS[v].data, rd);
            OP_PRB: begin
               do_prb(VECS[v].addr, VECS[v].data[1:0], h);
               check(h == VECS[v].exp[0], $sformatf("R%0d", VECS[v].req),
                     $sformatf("vec %0d prb_hit", v), {31'h0, h}, VECS[v].exp);
            end
            default: begin
               do_ctl(VECS[v].data);
               check(ctl_q == VECS[v].exp, $sformatf("R%0d", VECS[v].req),
                     $sformatf("vec %0d ctl_q", v), ctl_q, VECS[v].exp);
            end
         endcase
         check(mem_cnt - m0 == int'(VECS[v].nmem), $sformatf("R%0d", VECS[v].req),
               $sformatf("vec %0d mem transfers", v), mem_cnt - m0, {29'h0, VECS[v].nmem});
         check(wr_cnt - w0 == int'(VECS[v].nwr), $sformatf("R%0d", VECS[v].req),
               $sformatf("vec %0d mem writes", v), wr_cnt - w0, {29'h0, VECS[v].nwr});
      end

      // R9: same-cycle arrival, probe wins
      race(16'h0004, 16'h0008, 0, tc, tp);
      check(tp >= 0 && tp < tc, "R9", "probe before cpu (same cycle)", tp, tc);

      // R9: probe during a slow cpu miss waits for it
      lat = 5;
      race(16'h00C4, 16'h0008, 2, tc, tp);
      check(tc >= 0 && tc < tp, "R9", "cpu before late probe", tc, tp);

      // R10: disable raised mid-request does not stop allocation
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 16'h0104;
      @(negedge clk);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = 32'h40000000;
      @(negedge clk);
      ctl_we = 1'b0;
      for (int t = 0; t < 200; t++) begin
         if (cpu_done) break;
         @(negedge clk);
      end
      rd = cpu_rdata;
      cpu_req = 1'b0;
      check(rd == 32'h10000104, "R10", "in-flight read data", rd, 32'h10000104);
      lat = 0;
      do_ctl(32'h0);
      m0 = mem_cnt;
      do_cpu(1'b0, 16'h0104, 32'h0, rd);
      check(mem_cnt == m0, "R10", "line allocated under old mode", mem_cnt - m0, 32'h0);
      check(rd == 32'h10000104, "R10", "hit data", rd, 32'h10000104);

      // R11: handshake stability seen from outside
      check(hs_viol == 0, "R11", "request changed before ready", hs_viol, 32'h0);

      // R1: reset again empties the cache
      do_ctl(32'h40000000);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      check(ctl_q == 32'h0, "R1", "ctl_q after second reset", ctl_q, 32'h0);
      m0 = mem_cnt;
      do_cpu(1'b0, 16'h0104, 32'h0, rd);
      check(mem_cnt - m0 == 1, "R1", "line invalid after reset", mem_cnt - m0, 32'h1);

      summary_and_end();
   end

endmodule